// File: doc/BRIEF.md
# SCSI DMA Transfer Sequencer with Stop Control

This block runs the DMA side of one byte-wide data phase on a parallel SCSI bus controller. On the host side it uses a request/acknowledge DMA handshake: request out, plus acknowledge, read strobe, write strobe and end-of-process in. On the SCSI side it drives or answers the bus REQ/ACK handshake, in either the initiator role or the target role. Outgoing bytes pass through an output data register. Incoming bytes are held in an input data register until the host reads them.

A transfer can stop in three ways. The first is a qualified end-of-process from the host DMA side. The second is a bus phase mismatch, which applies in the initiator role only. The third is software clearing the DMA enable bit. Each stop records its cause in the status word. End-of-process and phase mismatch also raise a sticky interrupt. All asynchronous inputs pass through a synchronizer bank before the sequencer uses them.

Top module: `scsi_dma_term`

## Requirements
- R1: After reset, `drq`, `irq`, `req_out` and `ack_out` are low and `status` is 0x00.
- R2: Send direction: bytes written by the host under acknowledge plus write strobe appear on `scsi_dout`, in order, when the block asserts `ack_out` (initiator) or `req_out` (target). Receive direction: bytes captured from `scsi_din` during the bus handshake appear on `host_dout` when the host reads under acknowledge plus read strobe. In both directions `drq` rises again after each byte.
- R3: End-of-process counts only if it overlaps acknowledge plus a read or write strobe for at least EOP_MIN_CYC consecutive synchronized clocks. A shorter overlap has no effect: no interrupt, and `drq` returns after the byte.
- R4: A qualified end-of-process stops the transfer. It sets `irq`, sets cause code 1 in `status[3:2]` and drops `drq`. It leaves the enable bit (`status[1]`) set. DMA does not restart until the enable bit has been cleared and set again.
- R5: In the send direction, an end-of-process given with the last host byte completes only after that byte's bus handshake has finished. Until then `irq` stays low.
- R6: End-of-process asserted with neither read nor write strobe active sets `irq` with cause code 1, but the transfer continues: `drq` stays high and later bytes still move.
- R7: In the initiator role, a low `phase_ok` stops the transfer, sets `irq` with cause code 2 and drops `drq`.
- R8: While `ack_out` is held high, a phase mismatch is not acted on. Once the bus handshake releases `ack_out`, the mismatch stop and interrupt follow.
- R9: Clearing the enable bit (mode bit 1) during a transfer stops it. It drops `drq`, `req_out` and `ack_out`, records cause code 3 and raises no interrupt.
- R10: In the target role receiving data, after the enable bit is cleared with a byte waiting, no further `req_out` is issued. The waiting byte stays readable on `host_dout`.
- R11: `irq` stays set until a one-cycle `irq_clr` pulse clears it.
- R12: Status layout: bit 6 = `drq`, bit 5 = `irq`, bits 3:2 = cause (0 none, 1 end-of-process, 2 phase mismatch, 3 enable cleared), bit 1 = enable. All other bits read 0. Mode write layout: bit 1 = enable, bit 3 = target role, bit 4 = send direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| status | output | 8 | Status word |
| drq | output | 1 | DMA request to host |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| eop_n | input | 1 | End-of-process, active low, asynchronous |
| host_din | input | DW | Byte written by host |
| host_dout | output | DW | Input data register toward host |
| req_in | input | 1 | Bus REQ from target (initiator role) |
| ack_in | input | 1 | Bus ACK from initiator (target role) |
| phase_ok | input | 1 | High while bus phase matches expected phase |
| scsi_din | input | DW | Bus data in |
| scsi_dout | output | DW | Output data register toward bus |
| req_out | output | 1 | Bus REQ driven in target role |
| ack_out | output | 1 | Bus ACK driven in initiator role |
| irq | output | 1 | Sticky interrupt |

## Verification
The properties assume the role and direction bits change only in a mode write that also clears or sets the enable bit, never during an active transfer. They also assume each bus or host handshake input holds its level until the block has answered it. The bench follows both rules. It rewrites the mode with enable low before switching roles. Every peer step waits on the block's own `ack_out`, `req_out` or `drq` before the next edge, and strobes and data are held well beyond the synchronizer depth.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HWAIT, ST_HBUSY, ST_BREQ, ST_BREL, ST_DONE
  } xfer_st_e;

  typedef enum logic [1:0] {
    CZ_NONE = 2'd0, CZ_EOP = 2'd1, CZ_MISM = 2'd2, CZ_MODE = 2'd3
  } stop_cause_e;

  localparam int MB_EN   = 1;
  localparam int MB_TGT  = 3;
  localparam int MB_SEND = 4;

  function automatic logic [7:0] pack_status(logic drq, logic irq, logic en,
                                             stop_cause_e cz);
    return {1'b0, drq, irq, 1'b0, cz, en, 1'b0};
  endfunction

  function automatic logic run_reached(int unsigned run, int unsigned min_cyc);
    return (run + 1) == min_cyc;
  endfunction

endpackage

// File: rtl/scsi_sync_bank.sv
module scsi_sync_bank #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] r;
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = g_stg[g-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= src;
    end
  end
  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/scsi_eop_qual.sv
module scsi_eop_qual import scsi_dma_pkg::*; #(
  parameter int MIN_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eop,
  input  logic dack,
  input  logic rd,
  input  logic wr,
  output logic eop_ok,
  output logic eop_warn
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] run;
  logic overlap, loose, loose_q;

  assign overlap  = eop && dack && (rd || wr);
  assign loose    = eop && !rd && !wr;
  assign eop_ok   = overlap && run_reached(int'(run), MIN_CYC);
  assign eop_warn = loose && !loose_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      loose_q <= 1'b0;
    end else begin
      loose_q <= loose;
      if (!overlap)                  run <= '0;
      else if (run != CW'(MIN_CYC))  run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/scsi_xfer_seq.sv
module scsi_xfer_seq import scsi_dma_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          tgt,
  input  logic          send,
  input  logic          dack,
  input  logic          rd,
  input  logic          wr,
  input  logic          req,
  input  logic          ack,
  input  logic          pm,
  input  logic          eop_ok,
  input  logic          eop_warn,
  input  logic          irq_clr,
  input  logic [DW-1:0] host_din,
  input  logic [DW-1:0] scsi_din,
  output logic          drq,
  output logic          req_out,
  output logic          ack_out,
  output logic          irq,
  output stop_cause_e   cause,
  output logic [DW-1:0] odr,
  output logic [DW-1:0] idr,
  output logic          halt_eop,
  output logic          halt_mism,
  output logic          halt_mode
);
  xfer_st_e st;
  logic active, strobe, byte_end, eop_pend;

  always_comb begin
    strobe    = dack && (send ? wr : rd);
    active    = (st == ST_HWAIT) || (st == ST_HBUSY) ||
                (st == ST_BREQ)  || (st == ST_BREL);
    if (send) byte_end = (st == ST_BREL) && (tgt ? !ack : !req);
    else      byte_end = (st == ST_HBUSY) && !strobe;
    halt_mode = active && !dma_en;
    halt_mism = active && dma_en && !tgt && !pm && !ack_out;
    halt_eop  = active && dma_en && !halt_mism && byte_end &&
                (eop_pend || eop_ok);
    drq       = dma_en && (st == ST_HWAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      req_out  <= 1'b0;
      ack_out  <= 1'b0;
      irq      <= 1'b0;
      cause    <= CZ_NONE;
      odr      <= '0;
      idr      <= '0;
      eop_pend <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (halt_eop || halt_mism || (eop_warn && dma_en)) irq <= 1'b1;
      if (eop_warn && dma_en) cause <= CZ_EOP;
      if (!active)     eop_pend <= 1'b0;
      else if (eop_ok) eop_pend <= 1'b1;

      case (st)
        ST_IDLE:  if (dma_en) st <= send ? ST_HWAIT : ST_BREQ;
        ST_HWAIT: if (strobe) begin
                    if (send) odr <= host_din;
                    st <= ST_HBUSY;
                  end
        ST_HBUSY: if (!strobe) st <= ST_BREQ;
        ST_BREQ: begin
          if (tgt) begin
            if (!req_out) req_out <= 1'b1;
            else if (ack) begin
              if (!send) idr <= scsi_din;
              req_out <= 1'b0;
              st      <= ST_BREL;
            end
          end else if (req) begin
            if (!send) idr <= scsi_din;
            ack_out <= 1'b1;
            st      <= ST_BREL;
          end
        end
        ST_BREL: begin
          if (tgt) begin
            if (!ack) st <= ST_HWAIT;
          end else if (!req) begin
            ack_out <= 1'b0;
            st      <= ST_HWAIT;
          end
        end
        ST_DONE:  if (!dma_en) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase

      if (halt_mode) begin
        st <= ST_IDLE; req_out <= 1'b0; ack_out <= 1'b0; cause <= CZ_MODE;
      end else if (halt_mism) begin
        st <= ST_DONE; req_out <= 1'b0; ack_out <= 1'b0; cause <= CZ_MISM;
      end else if (halt_eop) begin
        st <= ST_DONE; req_out <= 1'b0; ack_out <= 1'b0; cause <= CZ_EOP;
      end
    end
  end
endmodule

// File: rtl/scsi_dma_term.sv
module scsi_dma_term import scsi_dma_pkg::*; #(
  parameter int DW          = 8,
  parameter int EOP_MIN_CYC = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [7:0]    mode_wdata,
  input  logic          irq_clr,
  output logic [7:0]    status,
  output logic          drq,
  input  logic          dack_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          eop_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  input  logic          req_in,
  input  logic          ack_in,
  input  logic          phase_ok,
  input  logic [DW-1:0] scsi_din,
  output logic [DW-1:0] scsi_dout,
  output logic          req_out,
  output logic          ack_out,
  output logic          irq
);
  localparam int NSYNC = 7;

  logic dma_en, tgt_role, send_dir;
  logic dack_s, rd_s, wr_s, eop_s, req_s, ack_s, pm_s;
  logic eop_ok, eop_warn, halt_eop, halt_mism, halt_mode;
  logic [NSYNC-1:0] raw_in, syn_in;
  stop_cause_e cause;
  logic unused_mode_bits;

  assign unused_mode_bits = ^{mode_wdata[7:5], mode_wdata[2], mode_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en <= 1'b0; tgt_role <= 1'b0; send_dir <= 1'b0;
    end else if (mode_we) begin
      dma_en   <= mode_wdata[MB_EN];
      tgt_role <= mode_wdata[MB_TGT];
      send_dir <= mode_wdata[MB_SEND];
    end
  end

  assign raw_in = {~dack_n, ~rd_n, ~wr_n, ~eop_n, req_in, ack_in, phase_ok};
  assign {dack_s, rd_s, wr_s, eop_s, req_s, ack_s, pm_s} = syn_in;

  scsi_sync_bank #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  scsi_eop_qual #(.MIN_CYC(EOP_MIN_CYC)) u_eop (
    .clk(clk), .rst_n(rst_n), .eop(eop_s), .dack(dack_s), .rd(rd_s),
    .wr(wr_s), .eop_ok(eop_ok), .eop_warn(eop_warn)
  );

  scsi_xfer_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .tgt(tgt_role),
    .send(send_dir), .dack(dack_s), .rd(rd_s), .wr(wr_s), .req(req_s),
    .ack(ack_s), .pm(pm_s), .eop_ok(eop_ok), .eop_warn(eop_warn),
    .irq_clr(irq_clr), .host_din(host_din), .scsi_din(scsi_din),
    .drq(drq), .req_out(req_out), .ack_out(ack_out), .irq(irq),
    .cause(cause), .odr(scsi_dout), .idr(host_dout),
    .halt_eop(halt_eop), .halt_mism(halt_mism), .halt_mode(halt_mode)
  );

  assign status = pack_status(drq, irq, dma_en, cause);
endmodule

// File: rtl/scsi_dma_term_chk.sv
module scsi_dma_term_chk (
  input logic clk,
  input logic rst_n,
  input logic drq,
  input logic dma_en,
  input logic tgt_role,
  input logic send_dir,
  input logic req_out,
  input logic ack_out,
  input logic irq,
  input logic irq_clr,
  input logic halt_eop,
  input logic halt_mism,
  input logic req_s,
  input logic ack_s
);
  a_r9_drq_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> dma_en);

  a_r9_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && $past(!dma_en)) |-> (!req_out && !ack_out && !drq));

  a_r4_eop_stop_drops_drq: assert property (@(posedge clk) disable iff (!rst_n)
    halt_eop |=> (!drq && irq));

  a_r7_mism_stop_drops_drq: assert property (@(posedge clk) disable iff (!rst_n)
    halt_mism |=> (!drq && irq));

  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r5_send_eop_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_eop && send_dir) |-> (tgt_role ? !ack_s : !req_s));
endmodule

bind scsi_dma_term scsi_dma_term_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drq(drq), .dma_en(dma_en),
  .tgt_role(tgt_role), .send_dir(send_dir), .req_out(req_out),
  .ack_out(ack_out), .irq(irq), .irq_clr(irq_clr), .halt_eop(halt_eop),
  .halt_mism(halt_mism), .req_s(req_s), .ack_s(ack_s)
);

// File: tb/tb_scsi_dma_term.sv
module tb_scsi_dma_term;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0, irq_clr = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eop_n = 1'b1;
  logic req_in = 1'b0, ack_in = 1'b0, phase_ok = 1'b1;
  logic [7:0] host_din = '0, scsi_din = '0;
  logic [7:0] status, host_dout, scsi_dout;
  logic drq, req_out, ack_out, irq;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  bit tb_send = 1'b0;
  string mon_tag = "R2";
  logic bus_prev = 1'b0, rd_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_dma_term dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .irq_clr(irq_clr), .status(status), .drq(drq), .dack_n(dack_n),
    .rd_n(rd_n), .wr_n(wr_n), .eop_n(eop_n), .host_din(host_din),
    .host_dout(host_dout), .req_in(req_in), .ack_in(ack_in),
    .phase_ok(phase_ok), .scsi_din(scsi_din), .scsi_dout(scsi_dout),
    .req_out(req_out), .ack_out(ack_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected byte at each bus or host data event
  always @(negedge clk) begin
    logic bus_up, rd_act;
    bus_up = ack_out | req_out;
    rd_act = !dack_n && !rd_n;
    if ((tb_send && bus_up && !bus_prev) || (!tb_send && rd_act && !rd_prev)) begin
      if (exp_q.size() == 0) chk(1'b0, {mon_tag, " unexpected byte"}, 0, 1);
      else begin
        logic [7:0] e, a;
        e = exp_q.pop_front();
        a = tb_send ? scsi_dout : host_dout;
        chk(a == e, {mon_tag, " data"}, a, e);
      end
    end
    bus_prev <= bus_up;
    rd_prev  <= rd_act;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle(input int n);
    repeat (n) tick();
    @(negedge clk);
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return drq;
      1: return ack_out;
      default: return req_out;
    endcase
  endfunction

  task automatic wait_out(input int which, input logic v, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (pick(which) != v && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (n >= 400) chk(1'b0, {tag, " timeout"}, pick(which), v);
  endtask

  task automatic mode_set(input logic [7:0] v);
    tick(); mode_we = 1'b1; mode_wdata = v;
    tick(); mode_we = 1'b0;
  endtask

  task automatic clear_irq();
    tick(); irq_clr = 1'b1;
    tick(); irq_clr = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] b, input int eop_cyc);
    wait_out(0, 1'b1, "R2 drq");
    exp_q.push_back(b);
    tick(); host_din = b; dack_n = 1'b0; wr_n = 1'b0;
    if (eop_cyc > 0) eop_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (i + 1 == eop_cyc) eop_n = 1'b1;
    end
    dack_n = 1'b1; wr_n = 1'b1; eop_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic host_read(input logic [7:0] b, input bit need_drq);
    if (need_drq) wait_out(0, 1'b1, "R2 drq");
    exp_q.push_back(b);
    tick(); dack_n = 1'b0; rd_n = 1'b0;
    repeat (6) tick();
    dack_n = 1'b1; rd_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic peer_as_target();   // block is initiator
    tick(); req_in = 1'b1;
    wait_out(1, 1'b1, "R2 ack_out");
    tick(); req_in = 1'b0;
    wait_out(1, 1'b0, "R2 ack_out release");
  endtask

  task automatic peer_as_initiator(); // block is target
    wait_out(2, 1'b1, "R2 req_out");
    tick(); ack_in = 1'b1;
    wait_out(2, 1'b0, "R2 req_out release");
    tick(); ack_in = 1'b0;
    repeat (4) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    chk(drq == 0 && irq == 0 && req_out == 0 && ack_out == 0, "R1 reset outputs",
        {drq, irq, req_out, ack_out}, 0);
    chk(status == 8'h00, "R12 reset status", status, 8'h00);
    rst_n = 1'b1;
    repeat (2) tick();

    // initiator send, EOP with last byte
    tb_send = 1'b1;
    mode_set(8'h12);
    host_write(8'h11, 0); peer_as_target();
    host_write(8'h22, 0); peer_as_target();
    host_write(8'h33, 8);
    settle(6);
    chk(irq == 0, "R5 no completion before bus handshake", irq, 0);
    chk(drq == 0, "R5 drq low while last byte pending", drq, 0);
    peer_as_target();
    settle(6);
    chk(irq == 1, "R4 eop interrupt", irq, 1);
    chk(status == 8'h26, "R12 status after eop stop", status, 8'h26);
    chk(status[1] == 1, "R4 enable kept", status[1], 1);
    settle(20);
    chk(drq == 0, "R4 no restart without rearm", drq, 0);
    chk(irq == 1, "R11 irq held until clear", irq, 1);
    clear_irq();
    settle(2);
    chk(irq == 0, "R11 irq cleared", irq, 0);

    // rearm, short EOP ignored
    mode_set(8'h00);
    mode_set(8'h12);
    settle(6);
    chk(drq == 1, "R4 rearm restarts drq", drq, 1);
    host_write(8'h44, 2); peer_as_target();
    settle(6);
    chk(irq == 0, "R3 short eop no interrupt", irq, 0);
    chk(drq == 1, "R3 short eop transfer continues", drq, 1);

    // EOP without strobe
    tick(); eop_n = 1'b0;
    repeat (3) tick();
    eop_n = 1'b1;
    settle(6);
    chk(irq == 1, "R6 loose eop interrupt", irq, 1);
    chk(status[3:2] == 2'd1, "R6 loose eop cause", status[3:2], 1);
    chk(drq == 1, "R6 drq stays high", drq, 1);
    clear_irq();
    host_write(8'h55, 0); peer_as_target();

    // mismatch while idle on bus
    tick(); phase_ok = 1'b0;
    settle(6);
    chk(irq == 1 && drq == 0, "R7 mismatch stop", {irq, drq}, 2'b10);
    chk(status == 8'h2A, "R12 status after mismatch", status, 8'h2A);
    clear_irq();
    tick(); phase_ok = 1'b1;
    mode_set(8'h00);
    mode_set(8'h12);

    // mismatch deferred while ack held
    host_write(8'h66, 0);
    tick(); req_in = 1'b1;
    wait_out(1, 1'b1, "R8 ack_out");
    tick(); phase_ok = 1'b0;
    settle(8);
    chk(irq == 0 && ack_out == 1, "R8 mismatch held off by ack", {irq, ack_out}, 2'b01);
    tick(); req_in = 1'b0;
    settle(8);
    chk(irq == 1 && status[3:2] == 2'd2, "R8 mismatch after ack release",
        {irq, status[3:2]}, 3'b110);
    clear_irq();
    tick(); phase_ok = 1'b1;
    mode_set(8'h00);

    // target send
    mode_set(8'h1A);
    host_write(8'h77, 0); peer_as_initiator();
    settle(4);
    chk(drq == 1, "R2 target send drq returns", drq, 1);
    mode_set(8'h00);

    // target receive, then clear enable with byte waiting
    tb_send = 1'b0;
    settle(2);
    tick(); scsi_din = 8'h5A;
    mode_set(8'h0A);
    peer_as_initiator();
    host_read(8'h5A, 1'b1);
    tick(); scsi_din = 8'hC3;
    peer_as_initiator();
    settle(4);
    chk(drq == 1, "R2 receive drq", drq, 1);
    mode_set(8'h08);
    settle(6);
    chk(drq == 0 && req_out == 0, "R9 clear drops drq and req", {drq, req_out}, 0);
    chk(status[3:2] == 2'd3 && irq == 0, "R9 cause code, no irq",
        {irq, status[3:2]}, 3'b011);
    settle(12);
    chk(req_out == 0, "R10 no further req", req_out, 0);
    mon_tag = "R10";
    host_read(8'hC3, 1'b0);
    settle(2);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule